// File: doc/BRIEF.md
# Command ring fetch control registers

This block holds the software-visible controls of a command ring fetch engine behind a small byte-wide register port. Software uses one byte to start and stop the engine and to enable an error interrupt. It reads a second byte to see whether a command fetch hit a memory data error, and it acknowledges that error by writing a one. A third, read-only byte reports the only ring geometry supported: 256 entries of four bytes each.

Stopping is a handshake. A write of zero to the run bit drops the request to the engine at once. The bit software reads back stays 1 until the engine reports that it is idle, so a readback of 0 proves that fetching has halted. The register port has no back-pressure: a write takes effect at the clock edge that samples it, and read data is returned one cycle after the read strobe.

Top module: `cmdring_ctl_regs`

## Requirements
- R1: After reset, `eng_run_req` and `irq` are 0, the control byte (0x4C) and the status byte (0x4D) read 0x00, and the size byte (0x4E) reads 0x42.
- R2: A read strobe at offset A puts that byte on `reg_rdata` at the next clock edge. In the control byte, bit 1 is the run bit, bit 0 is the error-interrupt enable, and bits 7:2 read 0.
- R3: A write to 0x4C with bit 1 set raises `eng_run_req` at the clock edge that takes the write, and the run bit reads back 1.
- R4: A write to 0x4C with bit 1 clear drops `eng_run_req` at the clock edge that takes the write. The run bit reads back 1 until the first edge at which `eng_idle` is high while `eng_run_req` is low, and it clears at that edge.
- R5: A write of 1 to the run bit while a stop is still pending cancels the stop. `eng_run_req` returns to 1 and the run bit never reads 0.
- R6: A one-cycle `eng_fetch_err` pulse sets status bit 0 (offset 0x4D) at the next edge.
- R7: A write to 0x4D with bit 0 set clears the status bit. A write with bit 0 clear leaves it unchanged. Status bits 7:1 always read 0.
- R8: When `eng_fetch_err` and a clearing write to 0x4D arrive in the same cycle, the status bit ends up 1.
- R9: `irq` is high exactly while the enable (control bit 0) and the status bit are both set, following their registered values.
- R10: The size byte reads 0x42: capability field bits 7:4 = 0100, select field bits 1:0 = 10, bits 3:2 = 0. Writes to 0x4E change nothing.
- R11: Reads of any offset other than 0x4C, 0x4D and 0x4E return 0x00. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_rd_en | input | 1 | Read strobe, one cycle per read |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd_en` |
| eng_idle | input | 1 | Engine reports it is halted |
| eng_fetch_err | input | 1 | Pulse: a command fetch returned bad data |
| eng_run_req | output | 1 | Run request to the fetch engine |
| irq | output | 1 | Memory-error interrupt |

## Verification
Read data is due exactly one edge after the read strobe. The bench queues the expected byte when it issues the read, and a monitor pops the queue on the falling edge after that strobe was captured. `eng_run_req` and `irq` change at the same edge that takes the write or the error pulse, so they are checked on the falling edge that follows. The stop handshake has no fixed delay. The bench model of the engine can be held busy, which pins the pending state so it can be read, and after release the bench waits well past the model's idle delay before it expects a readback of 0.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_SIZE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cmdring_decode.sv
module cmdring_decode
  import cmdring_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_OFS  = 8'h4C,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h4D,
  parameter logic [ADDR_W-1:0] SIZE_OFS = 8'h4E
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == CTL_OFS)       sel = SEL_CTL;
    else if (addr == STAT_OFS) sel = SEL_STAT;
    else if (addr == SIZE_OFS) sel = SEL_SIZE;
    else                       sel = SEL_NONE;
  end
endmodule

// File: rtl/cmdring_run_ctl.sv
module cmdring_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl,
  input  logic wr_run,
  input  logic wr_ie,
  input  logic eng_idle,
  output logic run_req,
  output logic run_bit,
  output logic ie_bit
);
  logic stop_done;
  logic run_bit_nxt;

  // the engine has acknowledged a stop once it is idle with no request
  assign stop_done = run_bit & ~run_req & eng_idle;

  always_comb begin
    run_bit_nxt = run_bit;
    if (wr_ctl && wr_run) run_bit_nxt = 1'b1;
    else if (stop_done)   run_bit_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_req <= 1'b0;
      run_bit <= 1'b0;
      ie_bit  <= 1'b0;
    end else begin
      run_bit <= run_bit_nxt;
      if (wr_ctl) begin
        run_req <= wr_run;
        ie_bit  <= wr_ie;
      end
    end
  end
endmodule

// File: rtl/cmdring_err_stat.sv
module cmdring_err_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_err,
  input  logic clr_req,
  output logic err_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)         err_flag <= 1'b0;
    else if (fetch_err) err_flag <= 1'b1;
    else if (clr_req)   err_flag <= 1'b0;
  end
endmodule

// File: rtl/cmdring_ctl_regs.sv
module cmdring_ctl_regs
  import cmdring_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_OFS  = 8'h4C,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h4D,
  parameter logic [ADDR_W-1:0] SIZE_OFS = 8'h4E,
  parameter logic [3:0] SIZE_CAP = 4'b0100,
  parameter logic [1:0] SIZE_SEL = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_idle,
  input  logic              eng_fetch_err,
  output logic              eng_run_req,
  output logic              irq
);
  localparam int unsigned RUN_POS  = 1;
  localparam int unsigned IE_POS   = 0;
  localparam int unsigned ERR_POS  = 0;
  localparam logic [DATA_W-1:0] SIZE_VAL =
    DATA_W'({SIZE_CAP, 2'b00, SIZE_SEL});

  reg_sel_e    sel;
  logic        wr_ctl;
  logic        clr_err;
  logic        run_bit;
  logic        ie_bit;
  logic        err_flag;
  logic [DATA_W-1:0] rd_mux;

  cmdring_decode #(
    .ADDR_W  (ADDR_W),
    .CTL_OFS (CTL_OFS),
    .STAT_OFS(STAT_OFS),
    .SIZE_OFS(SIZE_OFS)
  ) u_decode (
    .addr(reg_addr),
    .sel (sel)
  );

  assign wr_ctl  = reg_wr_en && (sel == SEL_CTL);
  assign clr_err = reg_wr_en && (sel == SEL_STAT) && reg_wdata[ERR_POS];

  cmdring_run_ctl u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctl  (wr_ctl),
    .wr_run  (reg_wdata[RUN_POS]),
    .wr_ie   (reg_wdata[IE_POS]),
    .eng_idle(eng_idle),
    .run_req (eng_run_req),
    .run_bit (run_bit),
    .ie_bit  (ie_bit)
  );

  cmdring_err_stat u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_err(eng_fetch_err),
    .clr_req  (clr_err),
    .err_flag (err_flag)
  );

  assign irq = ie_bit & err_flag;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CTL: begin
        rd_mux[RUN_POS] = run_bit;
        rd_mux[IE_POS]  = ie_bit;
      end
      SEL_STAT: rd_mux[ERR_POS] = err_flag;
      SEL_SIZE: rd_mux = SIZE_VAL;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/cmdring_ctl_chk.sv
module cmdring_ctl_chk #(
  parameter logic [7:0] CTL_OFS  = 8'h4C,
  parameter logic [7:0] STAT_OFS = 8'h4D,
  parameter logic [7:0] SIZE_OFS = 8'h4E
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_en,
  input logic       reg_rd_en,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       eng_idle,
  input logic       eng_fetch_err,
  input logic       eng_run_req,
  input logic       irq,
  input logic       run_bit,
  input logic       ie_bit,
  input logic       err_flag
);
  logic ctl_wr;
  logic unmapped;
  assign ctl_wr   = reg_wr_en && reg_addr == CTL_OFS;
  assign unmapped = reg_addr != CTL_OFS && reg_addr != STAT_OFS &&
                    reg_addr != SIZE_OFS;

  assert_run_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[1]) |=> (eng_run_req && run_bit));

  assert_run_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !reg_wdata[1]) |=> !eng_run_req);

  assert_run_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_bit && !(eng_idle && !eng_run_req)) |=> run_bit);

  assert_stop_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_bit && eng_idle && !eng_run_req && !(ctl_wr && reg_wdata[1]))
      |=> !run_bit);

  assert_req_needs_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_run_req |-> run_bit);

  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_fetch_err |=> err_flag);

  assert_irq_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_fetch_err && ie_bit && !ctl_wr) |=> irq);

  assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_bit |-> !irq);

  assert_size_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == SIZE_OFS) |=> reg_rdata == 8'h42);

  assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && unmapped) |=> reg_rdata == 8'h00);

  assert_reserved_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == CTL_OFS) |=> reg_rdata[7:2] == 6'd0);
endmodule

bind cmdring_ctl_regs cmdring_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_en    (reg_wr_en),
  .reg_rd_en    (reg_rd_en),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .eng_idle     (eng_idle),
  .eng_fetch_err(eng_fetch_err),
  .eng_run_req  (eng_run_req),
  .irq          (irq),
  .run_bit      (run_bit),
  .ie_bit       (ie_bit),
  .err_flag     (err_flag)
);

// File: tb/test_cmdring_ctl_regs.sv
module test_cmdring_ctl_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic       reg_rd_en = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       eng_idle;
  logic       eng_fetch_err = 1'b0;
  logic       eng_run_req;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  cmdring_ctl_regs i_cmdring_ctl_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_idle(eng_idle), .eng_fetch_err(eng_fetch_err),
    .eng_run_req(eng_run_req), .irq(irq)
  );

  // engine model: idle a few cycles after the request drops
  localparam int IDLE_LAT = 3;
  int  idle_cnt = 0;
  bit  hold_busy = 1'b0;
  always @(posedge clk) begin
    if (!rst_n || eng_run_req) idle_cnt <= 0;
    else if (idle_cnt < IDLE_LAT) idle_cnt <= idle_cnt + 1;
  end
  assign eng_idle = !hold_busy && !eng_run_req && (idle_cnt == IDLE_LAT);

  // scoreboard of expected read bytes
  typedef struct { logic [7:0] exp; string req; } rd_item_t;
  rd_item_t exp_q[$];
  bit sample_now = 1'b0;

  always @(posedge clk) sample_now <= reg_rd_en;

  always @(negedge clk) begin
    if (sample_now && exp_q.size() > 0) begin
      rd_item_t it;
      it = exp_q.pop_front();
      checks++;
      if (reg_rdata !== it.exp) begin
        fails++;
        $display("FAIL %s: read data actual %02h expected %02h",
                 it.req, reg_rdata, it.exp);
      end
    end
  end

  task automatic check_bit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
    rd_item_t it;
    it.exp = e; it.req = req;
    exp_q.push_back(it);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_bit(eng_run_req, 1'b0, "R1 run_req");
    check_bit(irq, 1'b0, "R1 irq");
    rd(8'h4C, 8'h00, "R1 ctl");
    rd(8'h4D, 8'h00, "R1 stat");
    rd(8'h4E, 8'h42, "R1 size");

    // R3 start with enable, R2 reserved bits read 0
    wr(8'h4C, 8'hFF);
    check_bit(eng_run_req, 1'b1, "R3 run_req");
    check_bit(irq, 1'b0, "R9 irq no err");
    rd(8'h4C, 8'h03, "R2 ctl readback");

    // R6 error pulse, R9 interrupt
    eng_fetch_err = 1'b1;
    @(negedge clk);
    eng_fetch_err = 1'b0;
    check_bit(irq, 1'b1, "R9 irq on err");
    rd(8'h4D, 8'h01, "R6 stat set");

    // R7 write zero no effect, write one clears
    wr(8'h4D, 8'h00);
    rd(8'h4D, 8'h01, "R7 w0 no effect");
    wr(8'h4D, 8'hFF);
    check_bit(irq, 1'b0, "R9 irq after clear");
    rd(8'h4D, 8'h00, "R7 w1 clears");

    // R8 set wins over clear
    eng_fetch_err = 1'b1;
    wr(8'h4D, 8'h01);
    eng_fetch_err = 1'b0;
    rd(8'h4D, 8'h01, "R8 set wins");

    // R9 enable off masks the interrupt
    wr(8'h4C, 8'h02);
    check_bit(irq, 1'b0, "R9 irq masked");
    rd(8'h4C, 8'h02, "R2 ctl ie off");
    wr(8'h4C, 8'h03);
    check_bit(irq, 1'b1, "R9 irq re-enabled");
    wr(8'h4D, 8'h01);
    wr(8'h4C, 8'h02);

    // R10 size write ignored, R11 unmapped
    wr(8'h4E, 8'h00);
    rd(8'h4E, 8'h42, "R10 size after write");
    wr(8'h50, 8'hFF);
    rd(8'h50, 8'h00, "R11 unmapped read");
    rd(8'h4C, 8'h02, "R11 ctl untouched");
    rd(8'h4D, 8'h00, "R11 stat untouched");
    wr(8'h4D, 8'hFE);
    rd(8'h4D, 8'h00, "R7 reserved stat bits");

    // R4 stop pending while engine busy
    hold_busy = 1'b1;
    wr(8'h4C, 8'h00);
    check_bit(eng_run_req, 1'b0, "R4 run_req drop");
    idle(3);
    rd(8'h4C, 8'h02, "R4 bit held while busy");

    // R5 cancel the pending stop
    wr(8'h4C, 8'h02);
    check_bit(eng_run_req, 1'b1, "R5 run_req back");
    hold_busy = 1'b0;
    idle(10);
    rd(8'h4C, 8'h02, "R5 stop cancelled");

    // R4 stop completes once engine idle
    wr(8'h4C, 8'h00);
    idle(10);
    rd(8'h4C, 8'h00, "R4 stop complete");
    check_bit(eng_run_req, 1'b0, "R4 run_req low");

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule